// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block guards a processor against a stalled program. A free-running 8-bit base counter advances on every clock cycle while the watchdog runs. Each wrap of that counter steps a postscaler counter. A 3-bit ratio select picks one of eight postscaler taps, and the chosen tap sets the time-out period. The ratio select is a configuration value and does not change while the watchdog runs. The watchdog runs when a configuration enable is set, or when that enable is clear and a software enable is set.

Software keeps the watchdog quiet by pulsing the clear command. The sleep-entry strobe resets the counters in the same way, and the count then goes on while the device sleeps. When the period runs out, the block raises a single-cycle pulse. That pulse appears on the reset request output if the device is awake, and on the wake request output if the sleep flag is set. After each time-out the counters start again from zero, so pulses repeat once per period for as long as nobody clears the watchdog.

Top module: `watchdog_postscaled`

## Requirements
- R1: The watchdog runs when `cfg_enable` or `sw_enable` is 1. While both are 0, no pulse is produced and the counters are held at zero, so a later enable starts a full period.
- R2: After reset release or enable, with select value s, the first pulse appears 256 * 2^s enabled clock cycles later. The ratios are 1, 2, 4, 8, 16, 32, 64 and 128 for s = 0 to 7.
- R3: Each pulse lasts exactly one cycle. The counters then restart from zero, so an uncleared watchdog pulses once every period.
- R4: A `clear_cmd` pulse resets the base counter and the postscaler. The next pulse comes one full period after the clearing cycle.
- R5: A `sleep_enter` pulse resets both counters in the same way as a clear. Counting then continues while `asleep` is high.
- R6: A time-out reached while `asleep` is 1 drives `wake_req`. A time-out reached while `asleep` is 0 drives `reset_req`.
- R7: Both outputs are 0 during and right after reset, and they are never 1 together.
- R8: A clear in the same cycle as the terminal count wins. No pulse is produced, and a new full period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Configuration enable; 1 forces the watchdog on |
| sw_enable | input | 1 | Software enable, used when cfg_enable is 0 |
| ratio_sel | input | 3 | Postscale select, ratio 2^ratio_sel, static at run time |
| clear_cmd | input | 1 | One-cycle command that restarts the period |
| sleep_enter | input | 1 | One-cycle strobe for sleep entry; restarts the period |
| asleep | input | 1 | High while the device sleeps |
| reset_req | output | 1 | One-cycle time-out pulse while awake |
| wake_req | output | 1 | One-cycle time-out pulse while asleep |

## Verification
Time-outs are checked at select values 0, 1, 3 and 7 to show that each tap gives its own period. A run of three uncleared periods shows that the counters restart after each pulse. Clear and sleep-entry strobes are issued part way through a period, and the software enable is dropped and raised again. Each of these moves the expected pulse to a cycle that differs from the uncleared schedule, so a missing clear or hold shows up as a pulse in the wrong cycle. A clear lined up on the exact terminal cycle separates clear priority from time-out priority. Switching the sleep flag between two time-outs shows that each pulse is routed to the right output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WDT_BASE_W = 8;
    localparam int unsigned WDT_SEL_W  = 3;

    typedef enum logic {
        TO_RESET = 1'b0,
        TO_WAKE  = 1'b1
    } to_kind_e;

    typedef struct packed {
        logic     fire;
        to_kind_e kind;
    } to_event_t;

    function automatic to_kind_e route_kind(input logic sleeping);
        return sleeping ? TO_WAKE : TO_RESET;
    endfunction

endpackage

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
    parameter int unsigned W = wdt_pkg::WDT_BASE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic carry
);
    localparam logic [W-1:0] CNT_TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign carry = run && !clr && (cnt_q == CNT_TOP);

    AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!run || clr) |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
    parameter int unsigned SEL_W = wdt_pkg::WDT_SEL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      run,
    input  logic                      clr,
    input  logic                      step,
    input  logic                      wrap,
    output logic [(1 << SEL_W)-1:0]   taps
);
    localparam int unsigned NTAP = 1 << SEL_W;
    localparam int unsigned PS_W = NTAP - 1;

    logic [PS_W-1:0] ps_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !run || wrap) begin
            ps_q <= '0;
        end else if (step) begin
            ps_q <= ps_q + 1'b1;
        end
    end

    // tap i is reached on the 2^i-th base wrap: low i bits all ones
    assign taps[0] = 1'b1;
    for (genvar gi = 1; gi < NTAP; gi++) begin : g_tap
        assign taps[gi] = &ps_q[gi-1:0];
    end

    AST_PS_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && step && !wrap) |=> (ps_q == $past(ps_q) + 1'b1)); // R2

    AST_PS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && !step) |=> $stable(ps_q)); // R2

endmodule

// File: rtl/wdt_tap_mux.sv
module wdt_tap_mux #(
    parameter int unsigned SEL_W = wdt_pkg::WDT_SEL_W
) (
    input  logic [(1 << SEL_W)-1:0] taps,
    input  logic [SEL_W-1:0]        sel,
    output logic                    hit
);
    assign hit = taps[sel];
endmodule

// File: rtl/watchdog_postscaled.sv
module watchdog_postscaled
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_W = WDT_BASE_W,
    parameter int unsigned SEL_W  = WDT_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             sw_enable,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             clear_cmd,
    input  logic             sleep_enter,
    input  logic             asleep,
    output logic             reset_req,
    output logic             wake_req
);
    localparam int unsigned NTAP = 1 << SEL_W;

    logic            run;
    logic            restart;
    logic            carry;
    logic            hit;
    logic            terminal;
    logic [NTAP-1:0] taps;
    to_event_t       ev_d;
    to_event_t       ev_q;

    assign run      = cfg_enable || sw_enable;
    assign restart  = clear_cmd || sleep_enter;

    wdt_base_counter #(.W(BASE_W)) u_base (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .clr   (restart),
        .carry (carry)
    );

    wdt_postscaler #(.SEL_W(SEL_W)) u_post (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .clr  (restart),
        .step (carry),
        .wrap (terminal),
        .taps (taps)
    );

    wdt_tap_mux #(.SEL_W(SEL_W)) u_mux (
        .taps (taps),
        .sel  (ratio_sel),
        .hit  (hit)
    );

    assign terminal = carry && hit;

    always_comb begin
        ev_d.fire = terminal;
        ev_d.kind = route_kind(asleep);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign reset_req = ev_q.fire && (ev_q.kind == TO_RESET);
    assign wake_req  = ev_q.fire && (ev_q.kind == TO_WAKE);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (reset_req || wake_req) |=> !(reset_req || wake_req)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> !(reset_req || wake_req)); // R1

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !(reset_req || wake_req)); // R8

    AST_WAKE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (carry && hit && asleep) |=> wake_req); // R6

    AST_RESET_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (carry && hit && !asleep) |=> reset_req); // R6

endmodule

// File: tb/test_watchdog_postscaled.sv
`timescale 1ns/1ps
module test_watchdog_postscaled;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b0;
    logic       sw_enable = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       clear_cmd = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       asleep = 1'b0;
    logic       reset_req;
    logic       wake_req;

    always #10 clk = ~clk;

    watchdog_postscaled i_watchdog_postscaled (
        .clk         (clk),
        .rst         (rst),
        .cfg_enable  (cfg_enable),
        .sw_enable   (sw_enable),
        .ratio_sel   (ratio_sel),
        .clear_cmd   (clear_cmd),
        .sleep_enter (sleep_enter),
        .asleep      (asleep),
        .reset_req   (reset_req),
        .wake_req    (wake_req)
    );

    typedef struct {
        int    at;
        bit    wake;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    int   pulses_seen = 0;
    bit   done = 1'b0;
    bit   prev_pulse = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(input int at, input bit wake, input string tag);
        exp_t e;
        e.at = at;
        e.wake = wake;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drain(input string req);
        check(exp_q.size() == 0, req, "pending expected pulses", exp_q.size(), 0);
    endtask

    task automatic enter_reset(input logic [2:0] s, input bit cfg, input bit sw);
        @(negedge clk);
        rst = 1'b1;
        ratio_sel = s;
        cfg_enable = cfg;
        sw_enable = sw;
        repeat (3) @(negedge clk);
        check(!reset_req && !wake_req, "R7", "outputs during reset",
              int'(reset_req) + int'(wake_req), 0);
        rst = 1'b0;
    endtask

    // monitor: pops the scoreboard on every pulse seen at the ports
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (reset_req || wake_req) begin
                pulses_seen++;
                check(!(reset_req && wake_req), "R7", "both outputs high", 1, 0);
                check(!prev_pulse, "R3", "pulse longer than one cycle", 2, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected pulse at cycle", cyc, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(cyc == e.at, e.tag, "pulse cycle", cyc, e.at);
                    check(wake_req == e.wake, "R6", "wake routing", int'(wake_req), int'(e.wake));
                end
            end
            prev_pulse = reset_req || wake_req;
        end else begin
            prev_pulse = 1'b0;
        end
    end

    initial begin
        int c;
        int c1;
        int c2;
        int w;
        int r;
        int seen;

        repeat (3) @(negedge clk);
        check(!reset_req && !wake_req, "R7", "reset state",
              int'(reset_req) + int'(wake_req), 0);

        // R2 / R3: select 0, three back-to-back periods of 256 cycles
        enter_reset(3'd0, 1'b1, 1'b0);
        c = cyc;
        push(c + 256, 1'b0, "R2");
        push(c + 512, 1'b0, "R3");
        push(c + 768, 1'b0, "R3");
        wait_until(c + 800);
        drain("R3");

        // R1: both enables low, no pulse for a long window
        cfg_enable = 1'b0;
        seen = pulses_seen;
        c = cyc;
        wait_until(c + 1500);
        check(pulses_seen == seen, "R1", "pulses while disabled", pulses_seen - seen, 0);

        // R4: select 3 via the software enable alone, clear part way through
        enter_reset(3'd3, 1'b0, 1'b1);
        c = cyc;
        wait_until(c + 1000);
        clear_cmd = 1'b1;
        c1 = cyc;
        @(negedge clk);
        clear_cmd = 1'b0;
        push(c1 + 1 + 2048, 1'b0, "R4");
        wait_until(c1 + 1 + 2048 + 5);
        drain("R4");

        // R1: drop the software enable mid period, re-enable later
        c = cyc;
        wait_until(c + 500);
        sw_enable = 1'b0;
        wait_until(c + 800);
        sw_enable = 1'b1;
        c2 = cyc;
        push(c2 + 2048, 1'b0, "R1");
        wait_until(c2 + 2048 + 5);
        drain("R1");
        sw_enable = 1'b0;

        // R5 / R6: select 1, sleep entry restarts, time-out wakes
        enter_reset(3'd1, 1'b1, 1'b0);
        c = cyc;
        wait_until(c + 300);
        sleep_enter = 1'b1;
        asleep = 1'b1;
        c1 = cyc;
        @(negedge clk);
        sleep_enter = 1'b0;
        w = c1 + 1 + 512;
        push(w, 1'b1, "R5");
        wait_until(w + 5);
        drain("R5");
        asleep = 1'b0;
        r = w + 512;
        push(r, 1'b0, "R6");

        // R8: clear lands on the terminal cycle of the next period
        wait_until(r + 511);
        drain("R6");
        clear_cmd = 1'b1;
        @(negedge clk);
        clear_cmd = 1'b0;
        push(r + 1024, 1'b0, "R8");
        wait_until(r + 1024 + 5);
        drain("R8");
        cfg_enable = 1'b0;

        // R2: widest ratio, select 7
        enter_reset(3'd7, 1'b1, 1'b0);
        c = cyc;
        push(c + 32768, 1'b0, "R2");
        wait_until(c + 32768 + 5);
        drain("R2");
        cfg_enable = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule